// File: doc/BRIEF.md
# Gated Selectable-Source Clock Divider

This block derives one peripheral clock from two candidate sources: a slow reference and a fast synthesized clock. Both sources arrive as level waveforms, and the block oversamples them with a faster fabric clock `clk`. A select input picks the source. A divider field picks the ratio, and a build-time parameter chooses how that field is read: plus-one, doubled plus-one, or power of two. A fourth build option gives the bus-clock behaviour. In that option, select low passes the slow source straight through, and select high divides the fast source by a power of two.

The output is a registered level. It changes on the `clk` edge at which the chosen source is first sampled high. It can also follow the chosen source in pass-through mode, one `clk` cycle late. The select, the gate and the ratio are all captured only when the current output period ends. For this reason, reprogramming never shortens a phase that is already under way. When the source changes, the output is held low until the new source gives its first rising edge. Output high and low phases are therefore always whole multiples of a source period.

Top module: `gclk_divider`

## Requirements
- R1: While `rst_n` is low, and after its release, `clk_out` stays low until a gated-on period starts.
- R2: With parameter ENC = ENC_ONE (code 0), a `div_val` of n ≥ 1 gives an output period of n+1 source periods. An even ratio gives equal high and low phases.
- R3: An odd ratio gives a high phase of (N-1)/2 source periods and a low phase of (N+1)/2 source periods.
- R4: With ENC_ONE and `div_val` = 0, the output reproduces the selected source's high and low phase lengths.
- R5: With ENC = ENC_DOUBLE (code 1), a `div_val` of n divides by 2·(n+1), with equal phases.
- R6: With ENC = ENC_POW2 (code 2), a `div_val` of n divides by 2^(n+1), with equal phases. DIV_W must be at most 4.
- R7: `sel` = 0 takes `src_lo` as the source, and `sel` = 1 takes `src_pll`.
- R8: With ENC = ENC_BUS (code 3), `sel` = 0 passes `src_lo` through undivided. `sel` = 1 divides `src_pll` by 2^(k+1), where k is the `div_val` field.
- R9: `gate_en` = 1 runs the output. `gate_en` = 0 holds it low.
- R10: A new `div_val` written during a period takes effect only at the next period start. The current period keeps its old high and low lengths.
- R11: Clearing `gate_en` during a high phase lets that high phase finish at full length. The output then stays low.
- R12: After `sel` changes, every complete high pulse has either the old length or the new length. No shortened pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that oversamples both sources |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_lo | input | 1 | Slow reference source level |
| src_pll | input | 1 | Fast synthesized source level |
| sel | input | 1 | Source select: 0 slow, 1 fast |
| gate_en | input | 1 | Output enable, applied at period end |
| div_val | input | DIV_W | Divider field, read according to ENC |
| clk_out | output | 1 | Divided, gated clock level |

## Verification
The gate decision and the divider reload are both taken at the same period-end event. The bench provokes this collision directly. On the cycle the output rises, it clears the gate and writes a new ratio together. It then judges the result from three observations. The high phase in progress must last its full old length. The output must then stay low for a long window. Once the gate is set again, the period must show the new ratio. Source switches are checked in a similar way: the bench counts the length of every pulse around the change and confirms that each one is either the old length or the new length.

// File: rtl/gclk_pkg.sv
package gclk_pkg;

   typedef enum logic [1:0] {
      ENC_ONE    = 2'd0,
      ENC_DOUBLE = 2'd1,
      ENC_POW2   = 2'd2,
      ENC_BUS    = 2'd3
   } div_enc_e;

   // bits needed to hold the largest ratio a field of width w can request
   function automatic int ratio_width(div_enc_e enc, int w);
      case (enc)
         ENC_ONE:    return w + 1;
         ENC_DOUBLE: return w + 2;
         default:    return (1 << w) + 1;
      endcase
   endfunction

endpackage

// File: rtl/gclk_ratio_decode.sv
module gclk_ratio_decode
   import gclk_pkg::*;
#(
   parameter div_enc_e ENC   = ENC_ONE,
   parameter int       DIV_W = 4,
   parameter int       RW    = ratio_width(ENC, DIV_W)
) (
   input  logic [DIV_W-1:0] div_val,
   output logic [RW-1:0]    ratio,
   output logic             unity
);

   if (DIV_W < 1) begin : g_bad_width
      $error("gclk_ratio_decode: DIV_W must be at least 1");
   end
   if ((ENC == ENC_POW2 || ENC == ENC_BUS) && DIV_W > 4) begin : g_bad_pow
      $error("gclk_ratio_decode: power-of-two fields are limited to 4 bits");
   end

   if (ENC == ENC_ONE) begin : g_one
      always_comb begin
         ratio = RW'(div_val) + RW'(1);
         unity = (div_val == '0);
      end
   end else if (ENC == ENC_DOUBLE) begin : g_double
      always_comb begin
         ratio = (RW'(div_val) + RW'(1)) << 1;
         unity = 1'b0;
      end
   end else begin : g_pow
      always_comb begin
         ratio = RW'(1) << (32'(div_val) + 32'd1);
         unity = 1'b0;
      end
   end

   // a divided (non-unity) setting always splits into two non-empty phases
   always_comb begin
      if (!unity) begin
         p_ratio_min_r3: assert (ratio >= RW'(2))
            else $error("divided ratio below two");
      end
   end

endmodule

// File: rtl/gclk_src_edge.sv
module gclk_src_edge #(
   parameter int N_SRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src,
   output logic [N_SRC-1:0] rise
);

   if (N_SRC < 1) begin : g_bad_count
      $error("gclk_src_edge: N_SRC must be at least 1");
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      logic prev_q;
      // reset high so a source already high at release gives no false edge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b1;
         else        prev_q <= src[i];
      end
      assign rise[i] = src[i] & ~prev_q;
   end

endmodule

// File: rtl/gclk_period_core.sv
module gclk_period_core #(
   parameter int RW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    src,
   input  logic [1:0]    rise,
   input  logic          new_sel,
   input  logic          new_gate,
   input  logic [RW-1:0] new_ratio,
   input  logic          new_pass,
   output logic          clk_o
);

   if (RW < 2) begin : g_bad_rw
      $error("gclk_period_core: RW must be at least 2");
   end

   logic          act_sel, act_gate, act_pass, hold, out_q;
   logic [RW-1:0] act_ratio, cnt, half;
   logic          ev, lvl, at_end, wrap;

   assign ev     = rise[act_sel];
   assign lvl    = src[act_sel];
   assign half   = act_ratio >> 1;
   assign at_end = (cnt == act_ratio - RW'(1));
   assign wrap   = ev & (hold | act_pass | at_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_sel   <= 1'b0;
         act_gate  <= 1'b0;
         act_pass  <= 1'b1;
         act_ratio <= RW'(1);
         hold      <= 1'b0;
         cnt       <= '0;
         out_q     <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         if (new_sel != act_sel) begin
            // switch source, then wait low for its first rising edge
            act_sel <= new_sel;
            hold    <= 1'b1;
            out_q   <= 1'b0;
         end else begin
            act_gate  <= new_gate;
            act_ratio <= new_ratio;
            act_pass  <= new_pass;
            hold      <= 1'b0;
            out_q     <= new_gate;
         end
      end else if (ev) begin
         cnt   <= cnt + RW'(1);
         out_q <= act_gate && ((cnt + RW'(1)) < half);
      end else if (act_pass && !hold) begin
         out_q <= act_gate && lvl;
      end
   end

   assign clk_o = out_q;

   p_gate_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !act_gate |-> !out_q);

   p_ratio_on_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(act_ratio));

   p_gate_on_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(act_gate));

   p_rise_on_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_q && !ev && !(act_pass && !hold)) |=> !out_q);

   p_hold_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> !out_q);

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < act_ratio);

endmodule

// File: rtl/gclk_divider.sv
module gclk_divider
   import gclk_pkg::*;
#(
   parameter div_enc_e ENC   = ENC_ONE,
   parameter int       DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_lo,
   input  logic             src_pll,
   input  logic             sel,
   input  logic             gate_en,
   input  logic [DIV_W-1:0] div_val,
   output logic             clk_out
);

   localparam int RW = ratio_width(ENC, DIV_W);

   logic [1:0]    src_v, rise_v;
   logic [RW-1:0] ratio;
   logic          unity, pass_in;

   assign src_v = {src_pll, src_lo};

   gclk_src_edge #(.N_SRC(2)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src_v),
      .rise  (rise_v)
   );

   gclk_ratio_decode #(.ENC(ENC), .DIV_W(DIV_W), .RW(RW)) u_dec (
      .div_val (div_val),
      .ratio   (ratio),
      .unity   (unity)
   );

   // bus variant: select low bypasses the divider entirely
   if (ENC == ENC_BUS) begin : g_bus_pass
      assign pass_in = unity | ~sel;
   end else begin : g_plain_pass
      assign pass_in = unity;
   end

   gclk_period_core #(.RW(RW)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (src_v),
      .rise      (rise_v),
      .new_sel   (sel),
      .new_gate  (gate_en),
      .new_ratio (ratio),
      .new_pass  (pass_in),
      .clk_o     (clk_out)
   );

endmodule

// File: tb/gclk_divider_test.sv
module gclk_divider_test;
   import gclk_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 120;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0;
   logic       gate_en = 1'b0;
   logic [3:0] div_one = '0;
   logic [7:0] div_dbl = '0;
   logic [2:0] div_p2  = '0;
   logic [1:0] div_bus = '0;
   int         lo_ph = 0;
   int         pll_ph = 0;
   wire        src_lo  = (lo_ph < 3);   // 3 high, 3 low
   wire        src_pll = (pll_ph < 2);  // 2 high, 2 low
   wire        o_one, o_dbl, o_p2, o_bus;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      lo_ph  <= (lo_ph == 5) ? 0 : lo_ph + 1;
      pll_ph <= (pll_ph == 3) ? 0 : pll_ph + 1;
   end

   gclk_divider #(.ENC(ENC_ONE), .DIV_W(4)) uut (
      .clk(clk), .rst_n(rst_n), .src_lo(src_lo), .src_pll(src_pll),
      .sel(sel), .gate_en(gate_en), .div_val(div_one), .clk_out(o_one));
   gclk_divider #(.ENC(ENC_DOUBLE), .DIV_W(8)) uut_dbl (
      .clk(clk), .rst_n(rst_n), .src_lo(src_lo), .src_pll(src_pll),
      .sel(sel), .gate_en(gate_en), .div_val(div_dbl), .clk_out(o_dbl));
   gclk_divider #(.ENC(ENC_POW2), .DIV_W(3)) uut_p2 (
      .clk(clk), .rst_n(rst_n), .src_lo(src_lo), .src_pll(src_pll),
      .sel(sel), .gate_en(gate_en), .div_val(div_p2), .clk_out(o_p2));
   gclk_divider #(.ENC(ENC_BUS), .DIV_W(2)) uut_bus (
      .clk(clk), .rst_n(rst_n), .src_lo(src_lo), .src_pll(src_pll),
      .sel(sel), .gate_en(gate_en), .div_val(div_bus), .clk_out(o_bus));

   int   mon_sel = 0;
   logic watched;
   always_comb begin
      case (mon_sel)
         1:       watched = o_dbl;
         2:       watched = o_p2;
         3:       watched = o_bus;
         default: watched = o_one;
      endcase
   end

   typedef struct { int hi; int lo; string tag; } exp_t;
   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   busy = 1'b0;

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic settle(int n);
      repeat (n) @(negedge clk);
   endtask

   // driver: queue one expected period for the chosen output
   task automatic expect_period(int which, int hi, int lo, string tag);
      exp_t e;
      e.hi = hi; e.lo = lo; e.tag = tag;
      mon_sel = which;
      q.push_back(e);
      busy = 1'b1;
      wait (busy == 1'b0);
   endtask

   // monitor: measure one full period of the watched output and compare
   initial begin
      forever begin
         @(negedge clk);
         if (busy && q.size() > 0) begin
            exp_t e;
            int   hi_c;
            int   lo_c;
            e = q.pop_front();
            while (watched)  @(negedge clk);
            while (!watched) @(negedge clk);
            hi_c = 0;
            while (watched) begin hi_c++; @(negedge clk); end
            lo_c = 0;
            while (!watched) begin lo_c++; @(negedge clk); end
            check(hi_c == e.hi, e.tag, "high phase", hi_c, e.hi);
            check(lo_c == e.lo, e.tag, "low phase", lo_c, e.lo);
            busy = 1'b0;
         end
      end
   end

   task automatic wait_rise();
      bit prev;
      prev = 1'b1;
      while (1) begin
         @(negedge clk);
         if (watched && !prev) break;
         prev = watched;
      end
   endtask

   // called on the first high sample; returns with the next rise sampled
   task automatic measure(output int hi, output int lo);
      hi = 0;
      while (watched)  begin hi++; @(negedge clk); end
      lo = 0;
      while (!watched) begin lo++; @(negedge clk); end
   endtask

   task automatic quiet(int which, int n, string req);
      int highs;
      mon_sel = which;
      highs = 0;
      repeat (n) begin
         @(negedge clk);
         if (watched) highs++;
      end
      check(highs == 0, req, "high samples while gated", highs, 0);
   endtask

   task automatic pulse_lengths(int which, int n, int a, int b, string req);
      int  bad;
      int  len;
      bit  armed;
      mon_sel = which;
      bad = 0; len = 0; armed = 1'b0;
      repeat (n) begin
         @(negedge clk);
         if (watched) begin
            if (armed) len++;
         end else begin
            if (armed && len != 0 && len != a && len != b) bad++;
            armed = 1'b1;
            len = 0;
         end
      end
      check(bad == 0, req, "pulses of foreign length", bad, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog all actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int hi;
      int lo;
      settle(5);
      // R1: all outputs low in reset
      check(o_one == 1'b0 && o_dbl == 1'b0 && o_p2 == 1'b0 && o_bus == 1'b0,
            "R1", "outputs in reset", int'({o_one, o_dbl, o_p2, o_bus}), 0);
      rst_n = 1'b1;
      settle(20);
      check(o_one == 1'b0 && o_bus == 1'b0, "R1", "outputs after reset, gate off",
            int'({o_one, o_bus}), 0);

      // fast source, each encoding
      sel = 1'b1; gate_en = 1'b1;
      div_one = 4'd3; div_dbl = 8'd2; div_p2 = 3'd2; div_bus = 2'd1;
      settle(SETTLE);
      expect_period(0, 8, 8, "R2");
      expect_period(1, 12, 12, "R5");
      expect_period(2, 16, 16, "R6");
      expect_period(3, 8, 8, "R8");

      div_one = 4'd4;                     // ratio 5, odd
      settle(SETTLE);
      expect_period(0, 8, 12, "R3");

      div_one = 4'd0;                     // unity: follow fast source
      settle(SETTLE);
      expect_period(0, 2, 2, "R4");

      // switch to the slow source while watching pulse lengths
      mon_sel = 0;
      sel = 1'b0;
      pulse_lengths(0, 80, 2, 3, "R12");
      settle(SETTLE);
      expect_period(0, 3, 3, "R7");
      expect_period(3, 3, 3, "R8");
      expect_period(1, 18, 18, "R7");
      expect_period(2, 24, 24, "R6");

      div_one = 4'd2;                     // ratio 3 on slow source
      settle(SETTLE);
      expect_period(0, 6, 12, "R3");

      // gate off and back on
      gate_en = 1'b0;
      settle(SETTLE);
      quiet(0, 60, "R9");
      quiet(3, 60, "R9");
      gate_en = 1'b1;
      settle(SETTLE);
      expect_period(0, 6, 12, "R9");

      // divider rewrite mid-period
      sel = 1'b1; div_one = 4'd3;
      settle(SETTLE);
      mon_sel = 0;
      wait_rise();
      div_one = 4'd1;
      measure(hi, lo);
      check(hi == 8, "R10", "high of period in flight", hi, 8);
      check(lo == 8, "R10", "low of period in flight", lo, 8);
      measure(hi, lo);
      check(hi == 4, "R10", "high of next period", hi, 4);
      check(lo == 4, "R10", "low of next period", lo, 4);

      // gate off and divider change together, at a rising edge
      wait_rise();
      gate_en = 1'b0; div_one = 4'd3;
      hi = 0;
      while (watched) begin hi++; @(negedge clk); end
      check(hi == 4, "R11", "high phase completed after gate off", hi, 4);
      quiet(0, 40, "R11");
      gate_en = 1'b1;
      settle(SETTLE);
      expect_period(0, 8, 8, "R10");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule